// File: doc/BRIEF.md
# Protocol Timestamp Timer

This block keeps a 40-bit time base for scheduling radio protocol events. The time is split into two parts. A 16-bit sub-period counter runs from zero up to a programmable period value. A 24-bit overflow counter advances once each time the sub-period counter wraps. The full {overflow, counter} value can be snapshotted into a 40-bit capture register when a frame-start event arrives. A control bit can instead select the end of a transmission as the capture event.

Each of two compare channels pairs a 16-bit counter compare with a 24-bit overflow compare. A channel's strobe fires only in the overflow period whose number equals its overflow compare, at the moment the counter reaches its counter compare. Channel 0 drives the receive-start strobe and channel 1 drives the transmit-start strobe. Sticky flags record wraps and compare hits, and the block raises an interrupt while any flag is set.

Software reaches every register through a byte-wide port. All multi-byte values are little-endian. Reading the lowest time byte freezes the upper four bytes, so a read of all five bytes returns one coherent value.

Top module: `ptt_timer`

## Requirements
- R1: After reset, the time value, the capture register and all compare registers read 0. The period (addresses 5–6) reads 0xFFFF. Control (address 22) and flags (address 23) read 0. start_rx, start_tx and irq are low.
- R2: While control bit 0 (run) is 1, the counter rises by one each clock. In a cycle where the counter equals the period, the counter becomes 0 on the next cycle and the overflow counter rises by one. While run is 0, both counters hold.
- R3: The overflow counter wraps from 0xFFFFFF to 0 when the counter wraps.
- R4: A write to time addresses 0–4 replaces that byte of {overflow, counter}. Byte 0 is the counter's low byte and byte 4 is the overflow's high byte. The write is taken instead of counting in that cycle.
- R5: Reading address 0 returns the live low byte and latches bytes 1–4. Addresses 1–4 then return the latched bytes until address 0 is read again.
- R6: Control bit 1 selects the capture event: 0 selects sof_evt and 1 selects txend_evt. On the selected event, the {overflow, counter} value of that cycle is loaded into the capture register (addresses 7–11). The other event input leaves the capture register unchanged.
- R7: start_rx is high for the one cycle after a cycle in which run is 1, the counter equals compare 0 (addresses 12–13) and the overflow counter equals overflow compare 0 (addresses 16–18). start_tx behaves the same way with compare 1 (addresses 14–15) and overflow compare 1 (addresses 19–21).
- R8: Flags at address 23 are set on the clock edge of their event and are sticky. The flag bits are: bit 0 for a counter wrap; bits 1 and 2 for the counter equalling compare 0 or 1 while run is 1; bits 3 and 4 for a wrap into an overflow value equal to overflow compare 0 or 1. irq is high while any flag is set.
- R9: Writing 1s to address 23 clears the matching flags. If a bit is set and cleared in the same cycle, the set wins.
- R10: While run is 0, no strobe fires and no flag is set, even when the time equals a compare pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register byte write strobe |
| bus_rd | input | 1 | Register byte read strobe (needed for the snapshot latch) |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| sof_evt | input | 1 | Frame-start event pulse |
| txend_evt | input | 1 | Transmission-end event pulse |
| start_rx | output | 1 | Receive-start strobe (channel 0) |
| start_tx | output | 1 | Transmit-start strobe (channel 1) |
| irq | output | 1 | High while any flag is set |

## Verification
The assertions check the following on every cycle:
- counter stepping, wrapping and holding, including the overflow rollover;
- capture loading and holding;
- that the snapshot latch only moves on a low-byte read;
- that flags stay sticky, and that a strobe is always paired with its counter-compare flag.

Other behaviour can only be shown by the bench's scenarios:
- the exact count arithmetic across a sweep of small periods;
- write precedence over counting;
- coherence of a multi-byte read while the value rolls over;
- strobe timing relative to the overflow period that holds the match;
- the clear-versus-set behaviour seen through the register port.

// File: rtl/ptt_pkg.sv
// Shared constants for the protocol timestamp timer.
// Assumes: two compare channels; control and flag layouts are fixed here.
package ptt_pkg;
    localparam int NUM_CH       = 2;   // channel 0 -> receive start, channel 1 -> transmit start
    localparam int CTRL_RUN_BIT = 0;   // counting enable
    localparam int CTRL_SEL_BIT = 1;   // capture source: 0 frame start, 1 transmission end
    localparam int CTRL_W       = 2;
endpackage

// File: rtl/ptt_counter.sv
// Split time base: a sub-period counter that wraps at a programmable
// period and an overflow counter that advances on each wrap.
// Assumes: a load (software byte write) overrides counting in its cycle.
module ptt_counter #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic [CNT_W-1:0]       period,
    input  logic                   ld_en,
    input  logic [CNT_W+OVF_W-1:0] ld_val,
    output logic [CNT_W-1:0]       cnt,
    output logic [OVF_W-1:0]       ovf,
    output logic                   wrap
);
    // Wrap happens this cycle when running at the period end and not loading.
    assign wrap = run && !ld_en && (cnt == period);

    // Count, wrap or load the two counter halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= '0;
        end else if (ld_en) begin
            {ovf, cnt} <= ld_val;
        end else if (run) begin
            if (cnt == period) begin
                cnt <= '0;
                ovf <= ovf + OVF_W'(1);
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld_en && cnt != period) |=> (cnt == $past(cnt) + CNT_W'(1)) && $stable(ovf)); // R2
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0) && (ovf == $past(ovf) + OVF_W'(1))); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_en) |=> $stable(cnt) && $stable(ovf)); // R2
    AST_OVF_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ovf == '1) |=> (ovf == '0)); // R3
endmodule

// File: rtl/ptt_match.sv
// One compare channel: a counter compare qualified by an overflow compare,
// giving a registered one-cycle strobe plus flag-set pulses.
// Assumes: cnt/ovf/wrap come from ptt_counter in the same clock domain.
module ptt_match #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [OVF_W-1:0] ovf,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cmp,
    input  logic [OVF_W-1:0] ocmp,
    output logic             start,
    output logic             cnt_hit,
    output logic             ovf_enter
);
    // Counter compare hit, only while running.
    assign cnt_hit   = run && (cnt == cmp);
    // Wrapping into the overflow period named by the overflow compare.
    assign ovf_enter = wrap && ((ovf + OVF_W'(1)) == ocmp);

    // Strobe in the cycle after both compares agree.
    always_ff @(posedge clk) begin
        if (!rst_n) start <= 1'b0;
        else        start <= cnt_hit && (ovf == ocmp);
    end

    AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(run)); // R10
endmodule

// File: rtl/ptt_capture.sv
// Event capture of the full 40-bit time on a selectable event input.
// Assumes: event inputs are synchronous single-cycle pulses.
module ptt_capture #(
    parameter int TW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_txend,
    input  logic          sof_evt,
    input  logic          txend_evt,
    input  logic [TW-1:0] time_in,
    output logic [TW-1:0] cap
);
    logic evt;

    // Pick the event source chosen by software.
    assign evt = sel_txend ? txend_evt : sof_evt;

    // Snapshot the time on the chosen event.
    always_ff @(posedge clk) begin
        if (!rst_n)   cap <= '0;
        else if (evt) cap <= time_in;
    end

    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_txend ? txend_evt : sof_evt) |=> (cap == $past(time_in))); // R6
    AST_CAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_txend ? txend_evt : sof_evt) |=> $stable(cap)); // R6
endmodule

// File: rtl/ptt_timer.sv
// Protocol timestamp timer top: byte register port, split time base,
// event capture, two qualified compare channels and sticky flags.
// Assumes: CNT_W and OVF_W are multiples of 8; ADDR_W covers the map.
module ptt_timer #(
    parameter int CNT_W  = 16,
    parameter int OVF_W  = 24,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              sof_evt,
    input  logic              txend_evt,
    output logic              start_rx,
    output logic              start_tx,
    output logic              irq
);
    import ptt_pkg::*;

    localparam int TW     = CNT_W + OVF_W;
    localparam int TB     = TW / 8;
    localparam int CB     = CNT_W / 8;
    localparam int OB     = OVF_W / 8;
    localparam int NCH    = NUM_CH;
    localparam int FLG_W  = 1 + 2 * NCH;
    localparam int A_TIME = 0;
    localparam int A_PER  = A_TIME + TB;
    localparam int A_CAP  = A_PER + CB;
    localparam int A_CMP  = A_CAP + TB;
    localparam int A_OCMP = A_CMP + NCH * CB;
    localparam int A_CTRL = A_OCMP + NCH * OB;
    localparam int A_FLAG = A_CTRL + 1;

    logic [CNT_W-1:0]  period_q;
    logic [CNT_W-1:0]  cmp_q  [NCH];
    logic [OVF_W-1:0]  ocmp_q [NCH];
    logic [CTRL_W-1:0] ctrl_q;
    logic [FLG_W-1:0]  flags_q;
    logic [TW-1:8]     shadow_q;
    logic [CNT_W-1:0]  cnt;
    logic [OVF_W-1:0]  ovf;
    logic [TW-1:0]     live;
    logic [TW-1:0]     cap;
    logic [TW-1:0]     ld_val;
    logic              ld_en;
    logic              wrap;
    logic              run;
    logic [NCH-1:0]    start_vec;
    logic [NCH-1:0]    cnt_hit;
    logic [NCH-1:0]    ovf_enter;
    logic [FLG_W-1:0]  flag_set;
    logic [FLG_W-1:0]  flag_clr;

    assign run  = ctrl_q[CTRL_RUN_BIT];
    assign live = {ovf, cnt};

    // Merge a software byte write into the time value.
    always_comb begin
        ld_en  = 1'b0;
        ld_val = live;
        for (int b = 0; b < TB; b++) begin
            if (bus_wr && bus_addr == ADDR_W'(A_TIME + b)) begin
                ld_en              = 1'b1;
                ld_val[b*8 +: 8]   = bus_wdata;
            end
        end
    end

    ptt_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .period(period_q),
        .ld_en(ld_en), .ld_val(ld_val), .cnt(cnt), .ovf(ovf), .wrap(wrap)
    );

    ptt_capture #(.TW(TW)) u_cap (
        .clk(clk), .rst_n(rst_n), .sel_txend(ctrl_q[CTRL_SEL_BIT]),
        .sof_evt(sof_evt), .txend_evt(txend_evt), .time_in(live), .cap(cap)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        ptt_match #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_match (
            .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .ovf(ovf),
            .wrap(wrap), .cmp(cmp_q[k]), .ocmp(ocmp_q[k]),
            .start(start_vec[k]), .cnt_hit(cnt_hit[k]), .ovf_enter(ovf_enter[k])
        );
    end

    assign start_rx = start_vec[0];
    assign start_tx = start_vec[1];

    // Flag events and software clear mask.
    assign flag_set = {ovf_enter, cnt_hit, wrap};
    assign flag_clr = (bus_wr && bus_addr == ADDR_W'(A_FLAG)) ? bus_wdata[FLG_W-1:0] : '0;
    assign irq      = |flags_q;

    // Configuration register writes and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '1;
            for (int k = 0; k < NCH; k++) begin
                cmp_q[k]  <= '0;
                ocmp_q[k] <= '0;
            end
            ctrl_q  <= '0;
            flags_q <= '0;
        end else begin
            for (int b = 0; b < CB; b++) begin
                if (bus_wr && bus_addr == ADDR_W'(A_PER + b)) period_q[b*8 +: 8] <= bus_wdata;
            end
            for (int k = 0; k < NCH; k++) begin
                for (int b = 0; b < CB; b++) begin
                    if (bus_wr && bus_addr == ADDR_W'(A_CMP + k*CB + b)) cmp_q[k][b*8 +: 8] <= bus_wdata;
                end
                for (int b = 0; b < OB; b++) begin
                    if (bus_wr && bus_addr == ADDR_W'(A_OCMP + k*OB + b)) ocmp_q[k][b*8 +: 8] <= bus_wdata;
                end
            end
            if (bus_wr && bus_addr == ADDR_W'(A_CTRL)) ctrl_q <= bus_wdata[CTRL_W-1:0];
            flags_q <= (flags_q & ~flag_clr) | flag_set;
        end
    end

    // Freeze the upper time bytes when the low byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         shadow_q <= '0;
        else if (bus_rd && bus_addr == ADDR_W'(A_TIME))     shadow_q <= live[TW-1:8];
    end

    // Read data multiplexer over the byte map.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_TIME)) bus_rdata = live[7:0];
        for (int b = 1; b < TB; b++) begin
            if (bus_addr == ADDR_W'(A_TIME + b)) bus_rdata = shadow_q[b*8 +: 8];
        end
        for (int b = 0; b < CB; b++) begin
            if (bus_addr == ADDR_W'(A_PER + b)) bus_rdata = period_q[b*8 +: 8];
        end
        for (int b = 0; b < TB; b++) begin
            if (bus_addr == ADDR_W'(A_CAP + b)) bus_rdata = cap[b*8 +: 8];
        end
        for (int k = 0; k < NCH; k++) begin
            for (int b = 0; b < CB; b++) begin
                if (bus_addr == ADDR_W'(A_CMP + k*CB + b)) bus_rdata = cmp_q[k][b*8 +: 8];
            end
            for (int b = 0; b < OB; b++) begin
                if (bus_addr == ADDR_W'(A_OCMP + k*OB + b)) bus_rdata = ocmp_q[k][b*8 +: 8];
            end
        end
        if (bus_addr == ADDR_W'(A_CTRL)) bus_rdata = 8'(ctrl_q);
        if (bus_addr == ADDR_W'(A_FLAG)) bus_rdata = 8'(flags_q);
    end

    AST_RX_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        start_rx |-> flags_q[1]); // R7
    AST_TX_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        start_tx |-> flags_q[2]); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(A_FLAG)) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R8
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_FLAG) && bus_wdata[0] && !wrap) |=> !flags_q[0]); // R9
    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!start_rx && !start_tx)); // R10
    AST_SHADOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == ADDR_W'(A_TIME)) |=> $stable(shadow_q)); // R5
endmodule

// File: tb/tb_ptt_timer.sv
module tb_ptt_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sof_evt = 1'b0;
    logic       txend_evt = 1'b0;
    logic       start_rx, start_tx, irq;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;
    logic [7:0] sel_bits = 8'h00;

    localparam int A_PER = 5, A_CAP = 7, A_CMP = 12, A_OCMP = 16, A_CTRL = 22, A_FLAG = 23;

    ptt_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sof_evt(sof_evt), .txend_evt(txend_evt),
        .start_rx(start_rx), .start_tx(start_tx), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge; one rising edge each.
    task automatic wr(input int a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = 5'(a);
        #5 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_multi(input int base, input int nb, output logic [39:0] v);
        logic [7:0] d;
        v = '0;
        for (int b = 0; b < nb; b++) begin
            rd(base + b, d);
            v[b*8 +: 8] = d;
        end
    endtask

    task automatic load_time(input logic [39:0] v);
        for (int b = 0; b < 5; b++) wr(b, v[b*8 +: 8]);
    endtask

    task automatic set_period(input logic [15:0] p);
        wr(A_PER, p[7:0]); wr(A_PER + 1, p[15:8]);
    endtask

    // Exactly n counting edges (n >= 1).
    task automatic run_for(input int n);
        wr(A_CTRL, sel_bits | 8'h01);
        idle(n - 1);
        wr(A_CTRL, sel_bits);
    endtask

    task automatic pulse(input bit txe);
        if (txe) txend_evt = 1'b1; else sof_evt = 1'b1;
        @(negedge clk);
        txend_evt = 1'b0; sof_evt = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [39:0] v;
        logic [7:0]  d;
        int          pers [4] = '{0, 1, 2, 5};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_multi(0, 5, v);       check("R1 time", v, 40'h0);
        rd_multi(A_PER, 2, v);   check("R1 period", v, 40'hFFFF);
        rd_multi(A_CAP, 5, v);   check("R1 capture", v, 40'h0);
        rd_multi(A_CMP, 4, v);   check("R1 compares", v, 40'h0);
        rd_multi(A_OCMP, 5, v);  check("R1 ovf compares", v, 40'h0);
        rd(A_CTRL, d);           check("R1 ctrl", 40'(d), 40'h0);
        rd(A_FLAG, d);           check("R1 flags", 40'(d), 40'h0);
        check("R1 outputs", {37'h0, start_rx, start_tx, irq}, 40'h0);

        // R2 count sweep over small periods
        foreach (pers[i]) begin
            set_period(16'(pers[i]));
            for (int n = 1; n <= 12; n++) begin
                load_time(40'h0);
                run_for(n);
                rd_multi(0, 5, v);
                check("R2 count", v, {24'(n / (pers[i] + 1)), 16'(n % (pers[i] + 1))});
            end
        end
        // R2 start at period end
        set_period(16'd3);
        load_time({24'h0000A0, 16'd3});
        run_for(1);
        rd_multi(0, 5, v);       check("R2 wrap from period", v, {24'h0000A1, 16'd0});
        // R2 hold while stopped
        idle(6);
        rd_multi(0, 5, v);       check("R2 hold stopped", v, {24'h0000A1, 16'd0});

        // R3 overflow rollover
        set_period(16'd2);
        load_time({24'hFFFFFF, 16'd2});
        run_for(1);
        rd_multi(0, 5, v);       check("R3 ovf wrap", v, 40'h0);
        // R4 byte write beats counting
        set_period(16'hFFFF);
        load_time(40'h0);
        wr(A_CTRL, 8'h01);
        idle(3);
        wr(0, 8'h40);
        wr(A_CTRL, 8'h00);
        rd_multi(0, 5, v);       check("R4 write precedence", v, 40'h41);
        load_time(40'hC3_0000_0000);
        rd_multi(0, 5, v);       check("R4 top byte write", v, 40'hC3_0000_0000);

        // R5 coherent read across a rollover
        load_time({24'h0000FF, 16'hFFF0});
        wr(A_CTRL, 8'h01);
        rd(0, d);                check("R5 live low byte", 40'(d), 40'hF0);
        idle(20);
        rd_multi(1, 4, v);       check("R5 frozen bytes", v, 40'h0000FFFF);
        rd(0, d);                check("R5 second low byte", 40'(d), 40'h09);
        rd_multi(1, 4, v);       check("R5 new snapshot", v, 40'h00010000);
        wr(A_CTRL, 8'h00);

        // R6 capture source selection
        sel_bits = 8'h00;
        load_time(40'h12_3456_789A);
        pulse(1'b0);
        rd_multi(A_CAP, 5, v);   check("R6 sof capture", v, 40'h12_3456_789A);
        load_time(40'h55_0000_0001);
        pulse(1'b1);
        rd_multi(A_CAP, 5, v);   check("R6 txend ignored", v, 40'h12_3456_789A);
        sel_bits = 8'h02;
        wr(A_CTRL, sel_bits);
        pulse(1'b1);
        rd_multi(A_CAP, 5, v);   check("R6 txend capture", v, 40'h55_0000_0001);
        load_time(40'h0);
        pulse(1'b0);
        rd_multi(A_CAP, 5, v);   check("R6 sof ignored", v, 40'h55_0000_0001);
        sel_bits = 8'h00;
        wr(A_CTRL, sel_bits);
        load_time(40'h0);
        wr(A_CTRL, 8'h01);
        idle(4);
        pulse(1'b0);
        wr(A_CTRL, 8'h00);
        rd_multi(A_CAP, 5, v);   check("R6 capture while running", v, 40'h4);

        // R7/R8 qualified strobes and flags
        set_period(16'd7);
        wr(A_CMP, 8'd3);  wr(A_CMP + 1, 8'd0);
        wr(A_CMP + 2, 8'd5); wr(A_CMP + 3, 8'd0);
        wr(A_OCMP, 8'd2); wr(A_OCMP + 1, 8'd0); wr(A_OCMP + 2, 8'd0);
        wr(A_OCMP + 3, 8'd4); wr(A_OCMP + 4, 8'd0); wr(A_OCMP + 5, 8'd0);
        load_time(40'h0);
        wr(A_FLAG, 8'h1F);
        wr(A_CTRL, 8'h01);
        for (int k = 0; k <= 50; k++) begin
            check("R7 start_rx", 40'(start_rx), 40'(k >= 1 && (k - 1) == 19));
            check("R7 start_tx", 40'(start_tx), 40'(k >= 1 && (k - 1) == 37));
            check("R8 irq", 40'(irq), 40'(k >= 4));
            idle(1);
        end
        wr(A_CTRL, 8'h00);
        rd(A_FLAG, d);           check("R8 all flags", 40'(d), 40'h1F);

        // R9 clear by writing ones
        wr(A_FLAG, 8'h03);
        rd(A_FLAG, d);           check("R9 partial clear", 40'(d), 40'h1C);
        wr(A_FLAG, 8'h1C);
        rd(A_FLAG, d);           check("R9 full clear", 40'(d), 40'h00);
        check("R9 irq low", 40'(irq), 40'h0);

        // R10 stopped at a matching time
        load_time({24'd2, 16'd3});
        for (int k = 0; k < 5; k++) begin
            check("R10 no strobe", {38'h0, start_rx, start_tx}, 40'h0);
            idle(1);
        end
        rd(A_FLAG, d);           check("R10 no flags", 40'(d), 40'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule